// File: doc/BRIEF.md
# Reorder Window with In-Order Commit

This block is a circular window of instruction slots that sits between decode and the execution units of an out-of-order core. Decode places instructions into the window in program order. Each new instruction takes the next free slot, and that slot's index becomes its tag. A later instruction that needs the result names this tag in place of a register. Each slot holds:

- an opcode;
- two source fields, each with a presence flag (the field holds a value when the flag is set, and a producer tag when it is clear);
- a destination register number;
- a result field;
- an exception cause.

In every cycle the window offers at most one slot to the execution units. The slot offered is the oldest one that is in use, has not yet been issued, and has both sources present. Execution units return results as a broadcast of tag, data and cause. The broadcast marks the producing slot done. It also fills every waiting source that names that tag, including a source being dispatched in the same cycle.

Results leave the window strictly from the oldest slot, once that slot is done, through a single write port to the architectural register file. If the oldest done slot carries a nonzero cause, nothing is written. Instead the window reports the cause and empties in one step: the allocation pointer is set equal to the retire pointer.

Top module: `reorder_window`

## Requirements
- R1: After a synchronous active-low reset the window is empty: disp_ready is 1, disp_tag is 0, and iss_valid, cm_we and exc_valid are 0.
- R2: Each accepted dispatch takes the slot shown on disp_tag. The tag starts at 0 after reset and advances by one per accepted dispatch, modulo DEPTH, wrapping from DEPTH-1 to 0.
- R3: While all DEPTH slots are occupied, disp_ready is 0 and a dispatch request is ignored. A request with ready operands then produces no issue.
- R4: A slot is offered on iss_valid/iss_tag/iss_op/iss_a/iss_b only when it is in use, not yet issued, and both sources are present. Each slot is offered exactly once.
- R5: When several slots are ready, the one offered is the oldest, counting from the retire pointer.
- R6: A completion broadcast (cmp_valid, cmp_tag, cmp_data) fills every waiting source whose tag field (its low log2(DEPTH) bits) equals cmp_tag. This includes a source dispatched in the same cycle, so the consumer can be offered in the next cycle with the broadcast value.
- R7: cm_we is 1 only when the oldest slot is done with a cause of 0. It then presents that slot's destination on cm_dest and its result on cm_data, and the slot is freed at the clock edge. A younger done slot never commits ahead of an older one.
- R8: When the oldest slot is done with a nonzero cause, exc_valid is 1 for one cycle with that cause on exc_cause. In that cycle cm_we, iss_valid and disp_ready are 0. The next cycle the window is empty and disp_tag equals the faulting slot's index.
- R9: A completion whose tag names a slot that is not in use changes nothing: it raises neither cm_we nor exc_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Decode offers an instruction |
| disp_ready | output | 1 | Window accepts a dispatch this cycle |
| disp_op | input | OP_W | Opcode of the offered instruction |
| disp_s1_rdy | input | 1 | Source 1 holds a value (1) or a producer tag (0) |
| disp_s1_val | input | DATA_W | Source 1 value, or tag in its low bits |
| disp_s2_rdy | input | 1 | Source 2 holds a value (1) or a producer tag (0) |
| disp_s2_val | input | DATA_W | Source 2 value, or tag in its low bits |
| disp_dest | input | REG_W | Architectural destination register |
| disp_tag | output | log2(DEPTH) | Tag of the slot the next dispatch takes |
| iss_valid | output | 1 | A ready slot is offered for execution |
| iss_tag | output | log2(DEPTH) | Tag of the offered slot |
| iss_op | output | OP_W | Opcode of the offered slot |
| iss_a | output | DATA_W | Source 1 value of the offered slot |
| iss_b | output | DATA_W | Source 2 value of the offered slot |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | log2(DEPTH) | Tag of the completing slot |
| cmp_data | input | DATA_W | Result value |
| cmp_cause | input | CAUSE_W | Exception cause, 0 for none |
| cm_we | output | 1 | Register-file write enable for the oldest slot |
| cm_dest | output | REG_W | Register-file write address |
| cm_data | output | DATA_W | Register-file write data |
| exc_valid | output | 1 | Exception taken, window flushed |
| exc_cause | output | CAUSE_W | Cause of the exception taken |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is dispatch and completion broadcast. The bench dispatches a consumer whose source names a producer tag in the very cycle that the producer's broadcast arrives. It then expects that consumer to be offered in the next cycle with the broadcast value, while the producer commits that same cycle.

The second pair is commit and a fresh allocation into the slot just freed after wrapping. This is judged from the disp_tag sequence and the order of cm_we writes.

// File: rtl/rob_pkg.sv
// Shared types for the reorder window.
// Assumes nothing beyond the enum encoding below being internal to the block.
package rob_pkg;

    // What the oldest slot does this cycle.
    typedef enum logic [1:0] {
        RET_IDLE   = 2'd0,
        RET_COMMIT = 2'd1,
        RET_FLUSH  = 2'd2
    } retire_e;

endpackage

// File: rtl/rob_ptrs.sv
// Allocation and retire pointers of the circular window.
// Each pointer carries one extra wrap bit, so that full and empty can be told apart.
// Assumes DEPTH is a power of two, alloc is never raised while full,
// and flush and retire are never raised in the same cycle.
module rob_ptrs #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             retire,
    input  logic             flush,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] tail_q;
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] occ;

    // Allocation pointer: advances on dispatch, snaps to the head on flush.
    always_ff @(posedge clk) begin
        if (!rst_n)      tail_q <= '0;
        else if (flush)  tail_q <= head_q;
        else if (alloc)  tail_q <= tail_q + 1'b1;
    end

    // Retire pointer: advances when the oldest slot commits.
    always_ff @(posedge clk) begin
        if (!rst_n)       head_q <= '0;
        else if (retire)  head_q <= head_q + 1'b1;
    end

    assign alloc_idx = tail_q[IDX_W-1:0];
    assign head_idx  = head_q[IDX_W-1:0];
    assign occ       = tail_q - head_q;
    assign empty     = (tail_q == head_q);
    assign full      = (tail_q[IDX_W] != head_q[IDX_W]) && (alloc_idx == head_idx);

    // R3: occupancy never exceeds the number of slots.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r3_occupancy: assert (occ <= PTR_W'(DEPTH))
                else $error("occupancy beyond depth");
        end
    end

    // R3: no allocation is accepted into a full window.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);

    // R8: a flush leaves the window empty in the next cycle.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/rob_pick.sv
// Oldest-first selector: returns the first ready slot scanning from the head.
// Purely combinational. The clock and reset serve only the assertions.
// Assumes DEPTH is a power of two, so index arithmetic wraps naturally.
module rob_pick #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ready,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] pick
);
    // Scan from youngest distance to oldest, so the oldest ready slot wins.
    always_comb begin
        logic [IDX_W-1:0] idx;
        found = 1'b0;
        pick  = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = head + IDX_W'(k);
            if (ready[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

    // R5: the chosen slot is always one that is ready.
    a_r5_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ready[pick]);

    // R4: nothing is chosen when no slot is ready.
    a_r4_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
        (ready == '0) |-> !found);

    // R5: the slot at the head is taken whenever it is ready.
    a_r5_head_first: assert property (@(posedge clk) disable iff (!rst_n)
        ready[head] |-> (pick == head));

endmodule

// File: rtl/reorder_window.sv
// Circular reorder window.
// Allocates slots in order and issues the oldest ready slot. It captures
// completion broadcasts (with a bypass into the dispatching slot), commits
// the oldest done slot to the register-file port, and flushes on a faulting head.
// Assumes DEPTH is a power of two, DATA_W >= log2(DEPTH), and that the
// execution units accept every offered slot in the cycle it is offered.
module reorder_window #(
    parameter int DEPTH   = 4,
    parameter int DATA_W  = 8,
    parameter int OP_W    = 4,
    parameter int REG_W   = 3,
    parameter int CAUSE_W = 3,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_valid,
    output logic               disp_ready,
    input  logic [OP_W-1:0]    disp_op,
    input  logic               disp_s1_rdy,
    input  logic [DATA_W-1:0]  disp_s1_val,
    input  logic               disp_s2_rdy,
    input  logic [DATA_W-1:0]  disp_s2_val,
    input  logic [REG_W-1:0]   disp_dest,
    output logic [IDX_W-1:0]   disp_tag,
    output logic               iss_valid,
    output logic [IDX_W-1:0]   iss_tag,
    output logic [OP_W-1:0]    iss_op,
    output logic [DATA_W-1:0]  iss_a,
    output logic [DATA_W-1:0]  iss_b,
    input  logic               cmp_valid,
    input  logic [IDX_W-1:0]   cmp_tag,
    input  logic [DATA_W-1:0]  cmp_data,
    input  logic [CAUSE_W-1:0] cmp_cause,
    output logic               cm_we,
    output logic [REG_W-1:0]   cm_dest,
    output logic [DATA_W-1:0]  cm_data,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause
);
    import rob_pkg::*;

    // Slot state.
    logic [DEPTH-1:0]   use_q, exec_q, p1_q, p2_q, done_q;
    logic [DATA_W-1:0]  s1_q    [DEPTH];
    logic [DATA_W-1:0]  s2_q    [DEPTH];
    logic [DATA_W-1:0]  data_q  [DEPTH];
    logic [OP_W-1:0]    op_q    [DEPTH];
    logic [REG_W-1:0]   dest_q  [DEPTH];
    logic [CAUSE_W-1:0] cause_q [DEPTH];

    logic [IDX_W-1:0] alloc_idx, head_idx, pick;
    logic             full, empty, found, alloc;
    logic [DEPTH-1:0] ready;
    retire_e          ret_kind;
    logic             commit_go, flush_go;
    logic             byp1, byp2;

    // Decide what the oldest slot does this cycle.
    always_comb begin
        ret_kind = RET_IDLE;
        if (use_q[head_idx] && done_q[head_idx]) begin
            ret_kind = (cause_q[head_idx] != '0) ? RET_FLUSH : RET_COMMIT;
        end
    end

    assign commit_go  = (ret_kind == RET_COMMIT);
    assign flush_go   = (ret_kind == RET_FLUSH);
    assign disp_ready = !full && !flush_go;
    assign alloc      = disp_valid && disp_ready;
    assign disp_tag   = alloc_idx;

    // A dispatching source that names the broadcast tag takes the value at once.
    assign byp1 = !disp_s1_rdy && cmp_valid && (disp_s1_val[IDX_W-1:0] == cmp_tag);
    assign byp2 = !disp_s2_rdy && cmp_valid && (disp_s2_val[IDX_W-1:0] == cmp_tag);

    // Per-slot readiness for issue.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rdy
        assign ready[g] = use_q[g] & ~exec_q[g] & p1_q[g] & p2_q[g];
    end

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc),
        .retire    (commit_go),
        .flush     (flush_go),
        .alloc_idx (alloc_idx),
        .head_idx  (head_idx),
        .full      (full),
        .empty     (empty)
    );

    rob_pick #(.DEPTH(DEPTH)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready),
        .head  (head_idx),
        .found (found),
        .pick  (pick)
    );

    assign iss_valid = found && !flush_go;
    assign iss_tag   = pick;
    assign iss_op    = op_q[pick];
    assign iss_a     = s1_q[pick];
    assign iss_b     = s2_q[pick];

    assign cm_we     = commit_go;
    assign cm_dest   = dest_q[head_idx];
    assign cm_data   = data_q[head_idx];
    assign exc_valid = flush_go;
    assign exc_cause = cause_q[head_idx];

    // Slot updates: dispatch load, issue mark, completion capture, wakeup, free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_q  <= '0;
            exec_q <= '0;
            p1_q   <= '0;
            p2_q   <= '0;
            done_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                s1_q[i]    <= '0;
                s2_q[i]    <= '0;
                data_q[i]  <= '0;
                op_q[i]    <= '0;
                dest_q[i]  <= '0;
                cause_q[i] <= '0;
            end
        end else if (flush_go) begin
            use_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc && (alloc_idx == IDX_W'(i))) begin
                    use_q[i]   <= 1'b1;
                    exec_q[i]  <= 1'b0;
                    done_q[i]  <= 1'b0;
                    op_q[i]    <= disp_op;
                    dest_q[i]  <= disp_dest;
                    cause_q[i] <= '0;
                    p1_q[i]    <= disp_s1_rdy || byp1;
                    s1_q[i]    <= byp1 ? cmp_data : disp_s1_val;
                    p2_q[i]    <= disp_s2_rdy || byp2;
                    s2_q[i]    <= byp2 ? cmp_data : disp_s2_val;
                end else begin
                    if (commit_go && (head_idx == IDX_W'(i))) begin
                        use_q[i] <= 1'b0;
                    end
                    if (iss_valid && (pick == IDX_W'(i))) begin
                        exec_q[i] <= 1'b1;
                    end
                    if (cmp_valid && use_q[i] && (cmp_tag == IDX_W'(i))) begin
                        data_q[i]  <= cmp_data;
                        cause_q[i] <= cmp_cause;
                        done_q[i]  <= 1'b1;
                    end
                    if (cmp_valid && use_q[i] && !p1_q[i] && (s1_q[i][IDX_W-1:0] == cmp_tag)) begin
                        s1_q[i] <= cmp_data;
                        p1_q[i] <= 1'b1;
                    end
                    if (cmp_valid && use_q[i] && !p2_q[i] && (s2_q[i][IDX_W-1:0] == cmp_tag)) begin
                        s2_q[i] <= cmp_data;
                        p2_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    // R7: every commit moves the retire point forward by exactly one slot.
    a_r7_commit_advance: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |=> (head_idx == IDX_W'($past(head_idx) + 1'b1)));

    // R4: a slot offered in one cycle is not offered again in the next.
    a_r4_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !(iss_valid && (iss_tag == $past(iss_tag))));

    // R1: an empty window neither commits nor flushes.
    a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !(cm_we || exc_valid));

endmodule

// File: tb/reorder_window_test.sv
// Self-checking bench for reorder_window at DEPTH=4.
module reorder_window_test;
    localparam int DEPTH  = 4;
    localparam int DATA_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic       disp_ready;
    logic [3:0] disp_op = '0;
    logic       disp_s1_rdy = 1'b0;
    logic [7:0] disp_s1_val = '0;
    logic       disp_s2_rdy = 1'b0;
    logic [7:0] disp_s2_val = '0;
    logic [2:0] disp_dest = '0;
    logic [1:0] disp_tag;
    logic       iss_valid;
    logic [1:0] iss_tag;
    logic [3:0] iss_op;
    logic [7:0] iss_a, iss_b;
    logic       cmp_valid = 1'b0;
    logic [1:0] cmp_tag = '0;
    logic [7:0] cmp_data = '0;
    logic [2:0] cmp_cause = '0;
    logic       cm_we;
    logic [2:0] cm_dest;
    logic [7:0] cm_data;
    logic       exc_valid;
    logic [2:0] exc_cause;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    reorder_window #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_s1_rdy(disp_s1_rdy), .disp_s1_val(disp_s1_val),
        .disp_s2_rdy(disp_s2_rdy), .disp_s2_val(disp_s2_val),
        .disp_dest(disp_dest), .disp_tag(disp_tag),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .cmp_cause(cmp_cause),
        .cm_we(cm_we), .cm_dest(cm_dest), .cm_data(cm_data),
        .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Record one check.
    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock edge and settle.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Clear all request inputs.
    task automatic idle();
        disp_valid = 1'b0;
        cmp_valid  = 1'b0;
        cmp_cause  = '0;
    endtask

    // Drive a dispatch request.
    task automatic disp(input int op, input bit r1, input int v1,
                        input bit r2, input int v2, input int dst);
        disp_valid  = 1'b1;
        disp_op     = 4'(op);
        disp_s1_rdy = r1;
        disp_s1_val = 8'(v1);
        disp_s2_rdy = r2;
        disp_s2_val = 8'(v2);
        disp_dest   = 3'(dst);
    endtask

    // Drive a completion broadcast.
    task automatic comp(input int tag, input int data, input int cause);
        cmp_valid = 1'b1;
        cmp_tag   = 2'(tag);
        cmp_data  = 8'(data);
        cmp_cause = 3'(cause);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 disp_ready", int'(disp_ready), 1);
        chk("R1 disp_tag", int'(disp_tag), 0);
        chk("R1 iss_valid", int'(iss_valid), 0);
        chk("R1 cm_we", int'(cm_we), 0);
        chk("R1 exc_valid", int'(exc_valid), 0);

        // ---- Fill, wake out of order, commit in order ----
        disp(1, 1, 8'h11, 1, 8'h22, 1);
        chk("R2 tag0", int'(disp_tag), 0);
        tick();
        chk("R4 iss slot0", int'(iss_valid), 1);
        chk("R4 iss tag0", int'(iss_tag), 0);
        chk("R4 iss op", int'(iss_op), 1);
        chk("R4 iss a", int'(iss_a), 8'h11);
        chk("R4 iss b", int'(iss_b), 8'h22);
        disp(2, 0, 0, 1, 8'h33, 2);
        chk("R2 tag1", int'(disp_tag), 1);
        tick();
        chk("R4 once", int'(iss_valid), 0);
        disp(3, 1, 8'h44, 0, 0, 3);
        chk("R2 tag2", int'(disp_tag), 2);
        tick();
        chk("R4 waiting", int'(iss_valid), 0);
        disp(4, 0, 1, 0, 2, 4);
        chk("R2 tag3", int'(disp_tag), 3);
        tick();
        chk("R3 full", int'(disp_ready), 0);
        chk("R4 none ready", int'(iss_valid), 0);
        disp(5, 1, 8'h5A, 1, 8'h5B, 5);
        tick();
        chk("R3 stall ignored", int'(iss_valid), 0);
        chk("R3 still full", int'(disp_ready), 0);
        idle();
        comp(0, 8'h55, 0);
        tick();
        idle();
        chk("R7 commit0 we", int'(cm_we), 1);
        chk("R7 commit0 dest", int'(cm_dest), 1);
        chk("R7 commit0 data", int'(cm_data), 8'h55);
        chk("R5 oldest tag", int'(iss_tag), 1);
        chk("R6 wake a", int'(iss_a), 8'h55);
        chk("R6 b kept", int'(iss_b), 8'h33);
        tick();
        chk("R5 next tag", int'(iss_tag), 2);
        chk("R6 wake b", int'(iss_b), 8'h55);
        chk("R5 next a", int'(iss_a), 8'h44);
        chk("R7 head not done", int'(cm_we), 0);
        chk("R2 ready after free", int'(disp_ready), 1);
        chk("R2 tag wraps", int'(disp_tag), 0);
        comp(2, 8'h77, 0);
        tick();
        idle();
        chk("R7 younger held", int'(cm_we), 0);
        chk("R6 half woken", int'(iss_valid), 0);
        comp(1, 8'h66, 0);
        tick();
        idle();
        chk("R7 commit1 we", int'(cm_we), 1);
        chk("R7 commit1 dest", int'(cm_dest), 2);
        chk("R7 commit1 data", int'(cm_data), 8'h66);
        chk("R6 both woken tag", int'(iss_tag), 3);
        chk("R6 both a", int'(iss_a), 8'h66);
        chk("R6 both b", int'(iss_b), 8'h77);
        tick();
        chk("R7 commit2 dest", int'(cm_dest), 3);
        chk("R7 commit2 data", int'(cm_data), 8'h77);
        comp(3, 8'h88, 0);
        tick();
        idle();
        chk("R7 commit3 we", int'(cm_we), 1);
        chk("R7 commit3 data", int'(cm_data), 8'h88);
        tick();
        chk("R7 drained", int'(cm_we), 0);
        chk("R2 empty tag", int'(disp_tag), 0);

        // ---- Dispatch in the same cycle as the producer's broadcast ----
        disp(6, 1, 1, 1, 2, 5);
        tick();
        chk("R4 C iss tag", int'(iss_tag), 0);
        disp(7, 0, 0, 1, 8'h12, 6);
        comp(0, 8'h99, 0);
        tick();
        idle();
        chk("R6 bypass valid", int'(iss_valid), 1);
        chk("R6 bypass tag", int'(iss_tag), 1);
        chk("R6 bypass a", int'(iss_a), 8'h99);
        chk("R7 same-cycle commit dest", int'(cm_dest), 5);
        chk("R7 same-cycle commit data", int'(cm_data), 8'h99);
        comp(1, 8'hAA, 0);
        tick();
        idle();
        chk("R7 C commit data", int'(cm_data), 8'hAA);
        tick();
        chk("R2 C tag", int'(disp_tag), 2);

        // ---- Exception flush ----
        disp(1, 1, 3, 1, 4, 1);
        tick();
        disp(2, 1, 5, 1, 6, 2);
        tick();
        disp(3, 0, 3, 1, 7, 3);
        tick();
        idle();
        comp(3, 8'h31, 0);
        tick();
        idle();
        chk("R7 younger done held", int'(cm_we), 0);
        chk("R8 no early exc", int'(exc_valid), 0);
        chk("R6 D wake a", int'(iss_a), 8'h31);
        comp(2, 0, 5);
        tick();
        idle();
        chk("R8 exc_valid", int'(exc_valid), 1);
        chk("R8 exc_cause", int'(exc_cause), 5);
        chk("R8 no commit", int'(cm_we), 0);
        chk("R8 no dispatch", int'(disp_ready), 0);
        chk("R8 no issue", int'(iss_valid), 0);
        tick();
        chk("R8 one cycle", int'(exc_valid), 0);
        chk("R8 empty ready", int'(disp_ready), 1);
        chk("R8 tag at fault", int'(disp_tag), 2);
        chk("R8 empty issue", int'(iss_valid), 0);
        comp(2, 8'h44, 6);
        tick();
        idle();
        chk("R9 stale no exc", int'(exc_valid), 0);
        chk("R9 stale no commit", int'(cm_we), 0);

        // ---- Sweep: single instructions around the ring ----
        for (int r = 0; r < 8; r++) begin
            int t;
            t = (2 + r) % DEPTH;
            disp(r, 1, r, 1, r + 1, (r % 7) + 1);
            chk("R2 sweep tag", int'(disp_tag), t);
            tick();
            idle();
            chk("R4 sweep iss tag", int'(iss_tag), t);
            chk("R4 sweep iss a", int'(iss_a), r);
            chk("R4 sweep iss b", int'(iss_b), r + 1);
            comp(t, 3 * r + 1, 0);
            tick();
            idle();
            chk("R7 sweep dest", int'(cm_dest), (r % 7) + 1);
            chk("R7 sweep data", int'(cm_data), 3 * r + 1);
            tick();
            chk("R7 sweep drained", int'(cm_we), 0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule